// File: doc/BRIEF.md
# Static Memory Bank Timing Sequencer

This block runs accesses from an internal request port onto an external bus of asynchronous static memories and burst-capable ROMs. The bus is split into eight banks, one chip select each. The top address bits of a request choose the bank. Each bank keeps its own timing set:
- a turnaround count,
- a read length,
- a second length, used for writes and for burst continuation beats,
- a small mode word: burst mode, wait-input enable and wait-input polarity.

A request is taken while the sequencer is idle. If the direction differs from the previous access, the block first inserts dead bus cycles. The active phase then holds chip select together with output enable or write enable. It lasts the programmed count plus one cycles, and longer while an enabled external wait input is at its active level. The completion cycle follows: it carries the acknowledge and, for reads, the captured data. For writes, chip select stays low one more cycle with write enable already released, so the data hold time is met.

The timing registers sit in a byte-addressed configuration space. Bank `b` occupies offsets `28*b + 0` (turnaround), `+4` (read length), `+8` (second length) and `+12` (mode).

Top module: `bankTiming`

## Requirements
- R1: After reset every bank reads back turnaround 0xF, read length 0x1F, second length 0x1F and mode 0. The register map is: bank b at byte offset 28*b, turnaround [3:0] at +0, read length [4:0] at +4, second length [4:0] at +8, mode at +12. The mode bits are bit0 = burst mode, bit1 = wait enable and bit2 = wait polarity (1 means active high).
- R2: Register bits above each field read as zero and keep no written value. The unused offsets +16, +20 and +24 of a group, and any address at or above 224, read as zero and ignore writes.
- R3: A read drives chip select and output enable low for (read length + 1) cycles. The next cycle releases all strobes, raises `ack` and presents on `rdata` the `memRdata` value sampled in the last active cycle.
- R4: A write drives chip select and write enable low for (second length + 1) cycles. In the next cycle `ack` is high, write enable is high and chip select is still low.
- R5: When a request's direction differs from that of the previous completed access, the block inserts T idle cycles before the active phase, with every chip select, output enable and write enable inactive. T is the turnaround value of the previous access's bank. With the same direction, or with no previous access, no cycle is inserted.
- R6: A read counts as a burst continuation beat when all of the following hold: its bank has burst mode set, the previous access was a read to the same bank, and its address is the previous address plus one. A continuation beat uses the second length. Any other read, including the first beat of a burst, uses the read length.
- R7: With wait enabled, the active phase cannot end while `memWait` equals the polarity bit. The phase ends in the first cycle in which the count has expired and wait is inactive. With wait disabled, `memWait` has no effect.
- R8: Only the chip select of the bank in `reqAddr[11:9]` is ever driven low. Output enable and write enable are never low together, and neither is low without a chip select.
- R9: A request presented while idle begins its turnaround or active phase in the next cycle. `ack` is a single-cycle pulse per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte address |
| cfgWdata | input | 5 | Configuration write data |
| cfgRdata | output | 32 | Configuration read data for cfgAddr |
| reqValid | input | 1 | Access request, held until ack |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 12 | Access address, top 3 bits select the bank |
| reqWdata | input | 16 | Write data |
| ack | output | 1 | Access completion pulse |
| rdata | output | 16 | Captured read data, valid with ack |
| memCsN | output | 8 | Per-bank chip selects, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memAddr | output | 12 | Memory address |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data |
| memWait | input | 1 | External wait, level set per bank |

## Verification
A wrong internal state shows at the pins within one access. A counter loaded from the wrong register, or a stale burst record, changes the number of cycles with output enable or write enable low by the difference between the two lengths. A stale direction record shows as dead cycles before the first strobe that appear where none are expected, or go missing where they are expected. A sequencer state that leaves the active phase early or late moves the `ack` pulse. A bad capture strobe puts data from another cycle on `rdata` in that same pulse. The bench sweeps banks, lengths, direction patterns, burst sequences and wait windows, and counts each phase cycle by cycle against arithmetic expectations.

// File: rtl/bankTimingPkg.sv
package bankTimingPkg;
  localparam int IDLE_W = 4;
  localparam int LEN_W  = 5;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_TURN, ST_ACT, ST_DONE} seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadTurn;
    logic loadAct;
    logic decCnt;
    logic capture;
    logic record;
    logic csOn;
    logic oeOn;
    logic weOn;
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic cntZero;
    logic waitHit;
    logic needTurn;
  } pathStatus_t;
endpackage

// File: rtl/bankTimingCtl.sv
module bankTimingCtl
  import bankTimingPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  pathStatus_t status,
  output ctlStrobe_t  strobe,
  output logic        ack
);
  seqState_t state, stateNext;
  logic finish;

  assign finish = status.cntZero && !status.waitHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (status.needTurn) begin
            strobe.loadTurn = 1'b1;
            stateNext = ST_TURN;
          end else begin
            strobe.loadAct = 1'b1;
            stateNext = ST_ACT;
          end
        end
      end
      ST_TURN: begin
        if (status.cntZero) begin
          strobe.loadAct = 1'b1;
          stateNext = ST_ACT;
        end else begin
          strobe.decCnt = 1'b1;
        end
      end
      ST_ACT: begin
        strobe.csOn = 1'b1;
        strobe.oeOn = !reqWrite;
        strobe.weOn = reqWrite;
        if (finish) begin
          strobe.capture = !reqWrite;
          stateNext = ST_DONE;
        end else begin
          strobe.decCnt = !status.cntZero;
        end
      end
      ST_DONE: begin
        strobe.csOn   = reqWrite;
        strobe.record = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign ack = (state == ST_DONE);
endmodule

// File: rtl/bankTimingPath.sv
module bankTimingPath
  import bankTimingPkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int CFG_AW      = 8,
  parameter int BANK_STRIDE = 28
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [CFG_AW-1:0]    cfgAddr,
  input  logic [LEN_W-1:0]     cfgWdata,
  output logic [31:0]          cfgRdata,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  ctlStrobe_t           strobe,
  output pathStatus_t          status,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_BANKS-1:0] memCsN,
  output logic                 memOeN,
  output logic                 memWeN,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  input  logic [DATA_W-1:0]    memRdata,
  input  logic                 memWait
);
  localparam int BANK_W   = $clog2(NUM_BANKS);
  localparam int OFF_IDLE = 0;
  localparam int OFF_RD   = 4;
  localparam int OFF_WR   = 8;
  localparam int OFF_MODE = 12;

  logic [IDLE_W-1:0] idleReg [NUM_BANKS];
  logic [LEN_W-1:0]  rdReg   [NUM_BANKS];
  logic [LEN_W-1:0]  wrReg   [NUM_BANKS];
  logic [MODE_W-1:0] modeReg [NUM_BANKS];

  logic [BANK_W-1:0] reqBank, lastBank;
  logic [ADDR_W-1:0] lastAddr;
  logic              lastValid, lastWrite;
  logic [LEN_W-1:0]  cnt, actLen;
  logic              burstBeat;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        idleReg[b] <= '1;
        rdReg[b]   <= '1;
        wrReg[b]   <= '1;
        modeReg[b] <= '0;
      end
    end else if (cfgWe) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (cfgAddr == CFG_AW'(b*BANK_STRIDE + OFF_IDLE)) idleReg[b] <= cfgWdata[IDLE_W-1:0];
        if (cfgAddr == CFG_AW'(b*BANK_STRIDE + OFF_RD))   rdReg[b]   <= cfgWdata;
        if (cfgAddr == CFG_AW'(b*BANK_STRIDE + OFF_WR))   wrReg[b]   <= cfgWdata;
        if (cfgAddr == CFG_AW'(b*BANK_STRIDE + OFF_MODE)) modeReg[b] <= cfgWdata[MODE_W-1:0];
      end
    end
  end

  always_comb begin
    cfgRdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (cfgAddr == CFG_AW'(b*BANK_STRIDE + OFF_IDLE)) cfgRdata = 32'(idleReg[b]);
      if (cfgAddr == CFG_AW'(b*BANK_STRIDE + OFF_RD))   cfgRdata = 32'(rdReg[b]);
      if (cfgAddr == CFG_AW'(b*BANK_STRIDE + OFF_WR))   cfgRdata = 32'(wrReg[b]);
      if (cfgAddr == CFG_AW'(b*BANK_STRIDE + OFF_MODE)) cfgRdata = 32'(modeReg[b]);
    end
  end

  // bank decode and access classification
  assign reqBank   = reqAddr[ADDR_W-1 -: BANK_W];
  assign burstBeat = !reqWrite && modeReg[reqBank][0] && lastValid && !lastWrite
                     && (lastBank == reqBank) && (reqAddr == lastAddr + ADDR_W'(1));
  assign actLen    = (reqWrite || burstBeat) ? wrReg[reqBank] : rdReg[reqBank];

  assign status.cntZero  = (cnt == '0);
  assign status.waitHit  = modeReg[reqBank][1] && (memWait == modeReg[reqBank][2]);
  assign status.needTurn = lastValid && (lastWrite != reqWrite) && (idleReg[lastBank] != '0);

  // shared phase counter, last-access record, read capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      lastValid <= 1'b0;
      lastWrite <= 1'b0;
      lastBank  <= '0;
      lastAddr  <= '0;
      rdata     <= '0;
    end else begin
      if (strobe.loadTurn)    cnt <= LEN_W'(idleReg[lastBank]) - LEN_W'(1);
      else if (strobe.loadAct) cnt <= actLen;
      else if (strobe.decCnt)  cnt <= cnt - LEN_W'(1);
      if (strobe.capture) rdata <= memRdata;
      if (strobe.record) begin
        lastValid <= 1'b1;
        lastWrite <= reqWrite;
        lastBank  <= reqBank;
        lastAddr  <= reqAddr;
      end
    end
  end

  // memory bus
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cs
    assign memCsN[g] = !(strobe.csOn && (reqBank == BANK_W'(g)));
  end
  assign memOeN   = !strobe.oeOn;
  assign memWeN   = !strobe.weOn;
  assign memAddr  = reqAddr;
  assign memWdata = reqWdata;
endmodule

// File: rtl/bankTiming.sv
module bankTiming
  import bankTimingPkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int CFG_AW      = 8,
  parameter int BANK_STRIDE = 28
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [CFG_AW-1:0]    cfgAddr,
  input  logic [LEN_W-1:0]     cfgWdata,
  output logic [31:0]          cfgRdata,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 ack,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_BANKS-1:0] memCsN,
  output logic                 memOeN,
  output logic                 memWeN,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  input  logic [DATA_W-1:0]    memRdata,
  input  logic                 memWait
);
  ctlStrobe_t  strobe;
  pathStatus_t status;

  bankTimingCtl ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .status(status), .strobe(strobe), .ack(ack)
  );

  bankTimingPath #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CFG_AW(CFG_AW), .BANK_STRIDE(BANK_STRIDE)
  ) path_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .strobe(strobe), .status(status), .rdata(rdata), .memCsN(memCsN),
    .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memWait(memWait)
  );
endmodule

// File: rtl/bankTimingChk.sv
module bankTimingChk #(
  parameter int NUM_BANKS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqWrite,
  input logic                 ack,
  input logic [NUM_BANKS-1:0] memCsN,
  input logic                 memOeN,
  input logic                 memWeN
);
  p_cs_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  p_oe_we_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  p_strobe_cs_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> (memCsN != '1));

  p_we_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (ack && (memCsN != '1)));

  p_read_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !reqWrite) |-> ((memCsN == '1) && memOeN));

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);
endmodule

bind bankTiming bankTimingChk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk(clk), .rstN(rstN), .reqWrite(reqWrite), .ack(ack),
  .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN)
);

// File: tb/bankTiming_tb_top.sv
module bankTiming_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [4:0]  cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        ack;
  logic [15:0] rdata;
  logic [7:0]  memCsN;
  logic        memOeN, memWeN;
  logic [11:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata;
  logic        memWait = 1'b0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int eIdle[8], eRd[8], eWr[8];
  logic prevValid = 1'b0, prevWrite = 1'b0;
  int prevBank = 0;

  always #10 clk = ~clk;

  bankTiming dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .ack(ack), .rdata(rdata), .memCsN(memCsN), .memOeN(memOeN),
    .memWeN(memWeN), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memWait(memWait)
  );

  // memory model: data is a fixed function of the address
  assign memRdata = {memAddr, 4'h0} ^ 16'h5A5A;

  function automatic logic [15:0] memFn(input logic [11:0] a);
    return {a, 4'h0} ^ 16'h5A5A;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input int bank, input int off, input logic [4:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 8'(bank*28 + off); cfgWdata = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgRead(input int addr, output logic [31:0] val);
    cfgAddr = 8'(addr);
    #1 val = cfgRdata;
  endtask

  task automatic setTiming(input int bank, input int idle, input int rd, input int wr);
    cfgWrite(bank, 0, 5'(idle)); eIdle[bank] = idle;
    cfgWrite(bank, 4, 5'(rd));   eRd[bank] = rd;
    cfgWrite(bank, 8, 5'(wr));   eWr[bank] = wr;
  endtask

  // Runs one access; counts dead cycles before the strobes, active cycles, and checks the shape.
  // waitK > 0: memWait sits at waitLvl until the waitK-th active cycle, then goes inactive.
  task automatic access(input logic wr, input logic [11:0] addr, input int waitK, input logic waitLvl,
                        output int pre, output int act, output logic [15:0] rd, output bit shapeOk);
    int guard;
    bit done;
    logic [7:0] expCs;
    expCs = ~(8'h01 << addr[11:9]);
    pre = 0; act = 0; shapeOk = 1; done = 0; guard = 0; rd = '0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = 16'hC3A0 ^ 16'(addr);
    memWait = (waitK > 0) ? waitLvl : ~waitLvl;
    while (!done && guard < 1000) begin
      @(negedge clk);
      guard++;
      if (ack) begin
        if (wr) shapeOk &= (memCsN == expCs) && memWeN && memOeN;
        else    shapeOk &= (memCsN == 8'hFF) && memWeN && memOeN;
        rd = rdata;
        done = 1;
      end else if (memCsN == 8'hFF) begin
        if (act != 0 || !memOeN || !memWeN) shapeOk = 0;
        pre++;
      end else begin
        act++;
        shapeOk &= (memCsN == expCs);
        if (wr) shapeOk &= !memWeN && memOeN;
        else    shapeOk &= !memOeN && memWeN;
        if (wr) shapeOk &= (memWdata == reqWdata);
        if (act == waitK) memWait = ~waitLvl;
      end
    end
    if (!done) shapeOk = 0;
    reqValid = 1'b0;
    memWait = ~waitLvl;
    @(negedge clk);
  endtask

  // access plus checks of dead cycles, active length, data and shape
  task automatic run(input logic wr, input logic [11:0] addr, input int expAct, input int waitK,
                     input logic waitLvl, input string tag);
    int pre, act, expPre, b;
    logic [15:0] rd;
    bit ok;
    b = int'(addr[11:9]);
    expPre = (prevValid && prevWrite != wr) ? eIdle[prevBank] : 0;
    access(wr, addr, waitK, waitLvl, pre, act, rd, ok);
    check(pre == expPre, {tag, " R5 turnaround"}, pre, expPre);
    check(act == expAct, {tag, " active length"}, act, expAct);
    check(ok, {tag, " R8 strobe shape / R4 hold"}, ok, 1);
    if (!wr) check(rd == memFn(addr), {tag, " R3 read data"}, rd, memFn(addr));
    prevValid = 1'b1; prevWrite = wr; prevBank = b;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state of bus and registers
    check(memCsN == 8'hFF && memOeN && memWeN && !ack, "R1 bus idle after reset", memCsN, 8'hFF);
    for (int b = 0; b < 8; b++) begin
      cfgRead(b*28 + 0,  v); check(v == 32'hF,  "R1 turnaround reset", v, 32'hF);
      cfgRead(b*28 + 4,  v); check(v == 32'h1F, "R1 read length reset", v, 32'h1F);
      cfgRead(b*28 + 8,  v); check(v == 32'h1F, "R1 second length reset", v, 32'h1F);
      cfgRead(b*28 + 12, v); check(v == 32'h0,  "R1 mode reset", v, 0);
      eIdle[b] = 15; eRd[b] = 31; eWr[b] = 31;
    end

    // R2 upper bits, gaps and out-of-range space
    cfgWrite(3, 0, 5'h1F); cfgRead(3*28, v);
    check(v == 32'hF, "R2 turnaround upper bit dropped", v, 32'hF);
    cfgWrite(3, 12, 5'h1F); cfgRead(3*28 + 12, v);
    check(v == 32'h7, "R2 mode upper bits dropped", v, 32'h7);
    cfgWrite(3, 12, 5'h0);
    for (int off = 16; off <= 24; off += 4) begin
      cfgWrite(2, off, 5'h1F); cfgRead(2*28 + off, v);
      check(v == 0, "R2 unused offset reads zero", v, 0);
    end
    @(negedge clk); cfgWe = 1'b1; cfgAddr = 8'd224; cfgWdata = 5'h1F;
    @(negedge clk); cfgWe = 1'b0;
    cfgRead(224, v); check(v == 0, "R2 out-of-range reads zero", v, 0);
    for (int b = 0; b < 8; b++) begin
      cfgRead(b*28 + 4, v); check(v == 32'h1F, "R2 stray writes ignored", v, 32'h1F);
    end

    // R3 R9: reads with every short length on every bank
    for (int b = 0; b < 8; b++) setTiming(b, b % 5, b % 3, (b + 1) % 4);
    for (int b = 0; b < 8; b++) begin
      for (int n = 0; n < 4; n++) begin
        cfgWrite(b, 4, 5'(n)); eRd[b] = n;
        run(1'b0, {3'(b), 9'(n*7 + 1)}, n + 1, 0, 1'b1, "R3 R9 read sweep");
      end
    end
    for (int b = 0; b < 8; b++) setTiming(b, b % 5, b % 3, (b + 1) % 4);

    // R4 R5 R8: mixed directions across banks
    for (int i = 0; i < 24; i++) begin
      int b;
      logic w;
      b = (i * 3) % 8;
      w = 1'((i / 3) % 2);
      run(w, {3'(b), 9'(i*11)}, (w ? eWr[b] : eRd[b]) + 1, 0, 1'b1, w ? "R4 write mix" : "R3 read mix");
    end
    setTiming(6, 9, 2, 0);
    run(1'b0, {3'd6, 9'd40}, 3, 0, 1'b1, "R5 read before long turnaround");
    run(1'b1, {3'd1, 9'd41}, eWr[1] + 1, 0, 1'b1, "R5 write after bank-6 read");

    // R6 burst continuation
    setTiming(5, 0, 4, 1);
    cfgWrite(5, 12, 5'b001);
    run(1'b0, {3'd5, 9'd100}, 5, 0, 1'b1, "R6 burst first beat");
    run(1'b0, {3'd5, 9'd101}, 2, 0, 1'b1, "R6 burst beat 2");
    run(1'b0, {3'd5, 9'd102}, 2, 0, 1'b1, "R6 burst beat 3");
    run(1'b0, {3'd5, 9'd110}, 5, 0, 1'b1, "R6 non-sequential read");
    run(1'b1, {3'd5, 9'd111}, 2, 0, 1'b1, "R6 write breaks burst");
    run(1'b0, {3'd5, 9'd112}, 5, 0, 1'b1, "R6 read after write is first beat");
    cfgWrite(5, 12, 5'b000);
    run(1'b0, {3'd5, 9'd113}, 5, 0, 1'b1, "R6 burst mode off");

    // R7 external wait
    setTiming(2, 0, 1, 2);
    cfgWrite(2, 12, 5'b110);
    for (int k = 0; k < 7; k++)
      run(1'b0, {3'd2, 9'(200 + 2*k)}, (k > 2) ? k : 2, k, 1'b1, "R7 wait active high");
    run(1'b1, {3'd2, 9'd230}, 6, 6, 1'b1, "R7 wait on write");
    cfgWrite(2, 12, 5'b010);
    for (int k = 1; k < 6; k++)
      run(1'b0, {3'd2, 9'(240 + 2*k)}, (k > 2) ? k : 2, k, 1'b0, "R7 wait active low");
    run(1'b0, {3'd2, 9'd260}, 2, 6, 1'b1, "R7 wrong level ignored");
    cfgWrite(2, 12, 5'b100);
    run(1'b0, {3'd2, 9'd262}, 2, 6, 1'b1, "R7 wait disabled ignored");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule